// File: doc/BRIEF.md
# Prefetching DMA Read FIFO Engine

This block copies a contiguous range of memory into an internal byte FIFO without waiting to be asked for each piece. A start command supplies a byte address and a byte count. From then on the engine issues read requests of up to `MAX_REQ` bytes whenever two things hold: a request slot is free (at most `MAX_PEND` reads in flight), and the FIFO has room for the bytes that request will return. FIFO room is booked when a request is issued, so returning data can never overflow. The memory side may answer requests in any order. Each answer lands in the slot named by its tag, and slots retire into the FIFO strictly in issue order.

A consumer removes N bytes (1 to `RD_MAX`) per read command. A read either succeeds in full or fails without touching the FIFO. Status shows whether the last request of the block has gone out (end of block) and whether anything is still pending (active). Two single-cycle pulses mark the end of each block and the moment the engine goes idle. A new block may be started as soon as the last request of the current block has been sent, even while its reads are still in flight. A stop command abandons the block and discards data still on the way back. A flush input empties the FIFO.

Top module: `dma_read_fifo`

## Requirements
- R1: Requests cover the block contiguously from the start address upward. Each request length equals the smaller of `MAX_REQ` and the bytes left, so the final request is shortened and never reads past the block end. `req_len_o` is never zero.
- R2: No more than `MAX_PEND` requests are outstanding at once (issued but not yet answered). The engine stops issuing when every slot is taken.
- R3: FIFO occupancy plus bytes booked for outstanding kept requests never exceeds `FIFO_BYTES`. With no reads, the engine issues exactly `FIFO_BYTES` bytes of requests and then holds `req_valid_o` low.
- R4: Bytes enter the FIFO in address order whatever order responses arrive in. A finished response waits behind older unfinished ones. Lane k of `rsp_data_i` (bits 8k+7:8k) holds the byte at request address + k.
- R5: A read of N bytes succeeds only if N is nonzero and the FIFO holds at least N bytes. The cycle after the read command, `rd_ok_o` pulses and lane k of `rd_data_o` holds the k-th oldest byte, with lanes at and above N zero. Otherwise `rd_fail_o` pulses and nothing is removed.
- R6: `eob_o` is high exactly when the next request address equals the block end address. `active_o` is low only when `eob_o` is high and no request slot is occupied.
- R7: A start is accepted only when `eob_o` is high and the length is nonzero. This includes while earlier requests are still pending. Otherwise the start is ignored and `start_err_o` pulses the following cycle.
- R8: A stop halts issuing (`eob_o` high and `req_valid_o` low the next cycle). Data from requests pending at the stop is discarded, and no end-of-block pulse follows.
- R9: `eob_evt_o` pulses for one cycle, the cycle after the handshake of a block's final request, once per block.
- R10: `idle_evt_o` pulses in the first cycle `active_o` is low. After a stop it fires once the last discarded response has retired. A start accepted in the `eob_evt_o` cycle keeps the engine active, so no idle pulse separates the two blocks.
- R11: A flush empties the FIFO. A read issued in the same cycle as a flush fails.
- R12: After reset, `eob_o` is high, `active_o` and `req_valid_o` are low and the FIFO is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Start a block |
| start_addr_i | input | ADDR_W | Block start byte address |
| start_len_i | input | ADDR_W | Block length in bytes |
| stop_i | input | 1 | Abandon the current block |
| flush_i | input | 1 | Empty the FIFO |
| req_valid_o | output | 1 | Read request offered |
| req_ready_i | input | 1 | Memory accepts the request |
| req_addr_o | output | ADDR_W | Request byte address |
| req_len_o | output | LEN_W | Request length in bytes |
| req_tag_o | output | TAG_W | Slot tag the answer must carry |
| rsp_valid_i | input | 1 | Response present |
| rsp_tag_i | input | TAG_W | Tag of the answered request |
| rsp_data_i | input | 8*MAX_REQ | Response bytes, lane k = address + k |
| rd_req_i | input | 1 | Consumer read command |
| rd_len_i | input | RL_W | Bytes to remove |
| rd_ok_o | output | 1 | Read succeeded (one cycle later) |
| rd_fail_o | output | 1 | Read refused (one cycle later) |
| rd_data_o | output | 8*RD_MAX | Read bytes, oldest in lane 0 |
| eob_o | output | 1 | Last request of the block has been sent |
| active_o | output | 1 | Block unfinished or requests pending |
| eob_evt_o | output | 1 | End-of-block pulse |
| idle_evt_o | output | 1 | Went-idle pulse |
| start_err_o | output | 1 | Refused start pulse |

## Verification
A request handshake takes effect at the edge where `req_valid_o` and `req_ready_i` are both high. The bench records the request just before that edge and compares its address and length with an arithmetic model of the block. Results of reads, starts and refused starts arrive one clock after the command, and `eob_evt_o` one clock after the final handshake. The bench samples each of these 1 ns after that edge. FIFO contents depend on response latency, so every data check waits a fixed number of settling cycles first, longer than the four-edge path of issue, answer, retire and count. It then reads and compares against bytes computed from the address.

// File: rtl/dmaf_pkg.sv
package dmaf_pkg;

  // Width helper that never returns zero.
  function automatic int unsigned bits_for(int unsigned n);
    return (n <= 1) ? 1 : $clog2(n);
  endfunction

  // Registered outcome of a consumer read.
  typedef enum logic [1:0] {
    RD_NONE = 2'd0,
    RD_PASS = 2'd1,
    RD_MISS = 2'd2
  } rd_res_e;

endpackage

// File: rtl/dmaf_issuer.sv
module dmaf_issuer #(
  parameter int ADDR_W  = 16,
  parameter int MAX_REQ = 4,
  parameter int LEN_W   = $clog2(MAX_REQ + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start_i,
  input  logic [ADDR_W-1:0] start_addr_i,
  input  logic [ADDR_W-1:0] start_len_i,
  input  logic              stop_i,
  input  logic              fire_i,
  output logic [ADDR_W-1:0] cand_addr_o,
  output logic [LEN_W-1:0]  cand_len_o,
  output logic              eob_o,
  output logic              eob_evt_o,
  output logic              start_err_o
);

  logic [ADDR_W-1:0] next_q;
  logic [ADDR_W-1:0] end_q;
  logic [ADDR_W-1:0] remain;
  logic              last_req;
  logic              start_ok;
  logic              eob_evt_q;
  logic              start_err_q;

  assign remain = end_q - next_q;
  assign eob_o  = (next_q == end_q);

  always_comb begin
    if (remain < ADDR_W'(MAX_REQ)) cand_len_o = LEN_W'(remain);
    else                           cand_len_o = LEN_W'(MAX_REQ);
  end

  assign cand_addr_o = next_q;
  assign last_req    = (ADDR_W'(cand_len_o) == remain);
  assign start_ok    = start_i && !stop_i && eob_o && (start_len_i != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      next_q      <= '0;
      end_q       <= '0;
      eob_evt_q   <= 1'b0;
      start_err_q <= 1'b0;
    end else begin
      if (stop_i) begin
        next_q <= end_q;
      end else if (start_ok) begin
        next_q <= start_addr_i;
        end_q  <= start_addr_i + start_len_i;
      end else if (fire_i) begin
        next_q <= next_q + ADDR_W'(cand_len_o);
      end
      eob_evt_q   <= fire_i && last_req && !stop_i;
      start_err_q <= start_i && !stop_i && !start_ok;
    end
  end

  assign eob_evt_o   = eob_evt_q;
  assign start_err_o = start_err_q;

endmodule

// File: rtl/dmaf_slots.sv
module dmaf_slots #(
  parameter int MAX_PEND = 4,
  parameter int MAX_REQ  = 4,
  parameter int LEN_W    = $clog2(MAX_REQ + 1),
  parameter int TAG_W    = dmaf_pkg::bits_for(MAX_PEND),
  parameter int PCNT_W   = $clog2(MAX_PEND + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 alloc_i,
  input  logic [LEN_W-1:0]     alloc_len_i,
  input  logic                 kill_i,
  input  logic                 rsp_valid_i,
  input  logic [TAG_W-1:0]     rsp_tag_i,
  input  logic [8*MAX_REQ-1:0] rsp_data_i,
  output logic [TAG_W-1:0]     alloc_tag_o,
  output logic                 slot_free_o,
  output logic [PCNT_W-1:0]    pend_cnt_o,
  output logic                 retire_o,
  output logic                 retire_keep_o,
  output logic [LEN_W-1:0]     retire_len_o,
  output logic [8*MAX_REQ-1:0] retire_data_o
);

  logic [TAG_W-1:0]     head_q;
  logic [TAG_W-1:0]     tail_q;
  logic [PCNT_W-1:0]    cnt_q;
  logic                 done_q [MAX_PEND];
  logic                 drop_q [MAX_PEND];
  logic [LEN_W-1:0]     len_q  [MAX_PEND];
  logic [8*MAX_REQ-1:0] data_q [MAX_PEND];

  function automatic logic [TAG_W-1:0] bump(logic [TAG_W-1:0] p);
    return (p == TAG_W'(MAX_PEND - 1)) ? '0 : p + 1'b1;
  endfunction

  assign slot_free_o   = (cnt_q != PCNT_W'(MAX_PEND));
  assign alloc_tag_o   = tail_q;
  assign pend_cnt_o    = cnt_q;
  assign retire_o      = (cnt_q != '0) && done_q[head_q];
  assign retire_keep_o = !drop_q[head_q] && !kill_i;
  assign retire_len_o  = len_q[head_q];
  assign retire_data_o = data_q[head_q];

  always_ff @(posedge clk) begin
    if (rst) begin
      head_q <= '0;
      tail_q <= '0;
      cnt_q  <= '0;
    end else begin
      if (alloc_i)  tail_q <= bump(tail_q);
      if (retire_o) head_q <= bump(head_q);
      cnt_q <= cnt_q + PCNT_W'(alloc_i) - PCNT_W'(retire_o);
    end
  end

  // Per-slot completion and discard flags.
  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < MAX_PEND; i++) begin
        done_q[i] <= 1'b0;
        drop_q[i] <= 1'b0;
      end
    end else begin
      for (int i = 0; i < MAX_PEND; i++) begin
        if (alloc_i && tail_q == TAG_W'(i)) begin
          done_q[i] <= 1'b0;
          drop_q[i] <= kill_i;
        end else begin
          if (rsp_valid_i && rsp_tag_i == TAG_W'(i)) done_q[i] <= 1'b1;
          if (retire_o && head_q == TAG_W'(i))       done_q[i] <= 1'b0;
          if (kill_i)                                drop_q[i] <= 1'b1;
        end
      end
    end
  end

  // Slot payload storage, no reset needed.
  always_ff @(posedge clk) begin
    for (int i = 0; i < MAX_PEND; i++) begin
      if (alloc_i && tail_q == TAG_W'(i)) len_q[i] <= alloc_len_i;
      if (rsp_valid_i && rsp_tag_i == TAG_W'(i)) data_q[i] <= rsp_data_i;
    end
  end

endmodule

// File: rtl/dmaf_bytefifo.sv
module dmaf_bytefifo #(
  parameter int DEPTH  = 16,
  parameter int WR_MAX = 4,
  parameter int RD_MAX = 4,
  parameter int CNT_W  = $clog2(DEPTH + 1),
  parameter int WL_W   = $clog2(WR_MAX + 1),
  parameter int RL_W   = $clog2(RD_MAX + 1),
  parameter int PTR_W  = dmaf_pkg::bits_for(DEPTH)
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                push_i,
  input  logic [WL_W-1:0]     push_len_i,
  input  logic [8*WR_MAX-1:0] push_data_i,
  input  logic                flush_i,
  input  logic                rd_req_i,
  input  logic [RL_W-1:0]     rd_len_i,
  output logic [CNT_W-1:0]    count_o,
  output logic                rd_ok_o,
  output logic                rd_fail_o,
  output logic [8*RD_MAX-1:0] rd_data_o
);
  import dmaf_pkg::*;

  logic [7:0]       mem_q  [DEPTH];
  logic [7:0]       lane_q [RD_MAX];
  logic [PTR_W-1:0] wptr_q;
  logic [PTR_W-1:0] rptr_q;
  logic [CNT_W-1:0] cnt_q;
  rd_res_e          res_q;
  logic             pop;
  logic [CNT_W-1:0] push_n;
  logic [CNT_W-1:0] pop_n;

  assign pop    = rd_req_i && !flush_i && (rd_len_i != '0) && (cnt_q >= CNT_W'(rd_len_i));
  assign push_n = push_i ? CNT_W'(push_len_i) : '0;
  assign pop_n  = pop ? CNT_W'(rd_len_i) : '0;

  always_ff @(posedge clk) begin
    if (rst) begin
      wptr_q <= '0;
      rptr_q <= '0;
      cnt_q  <= '0;
      res_q  <= RD_NONE;
    end else begin
      wptr_q <= wptr_q + PTR_W'(push_n);
      if (flush_i) begin
        rptr_q <= wptr_q;
        cnt_q  <= push_n;
      end else begin
        rptr_q <= rptr_q + PTR_W'(pop_n);
        cnt_q  <= cnt_q + push_n - pop_n;
      end
      if (!rd_req_i) res_q <= RD_NONE;
      else           res_q <= pop ? RD_PASS : RD_MISS;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < WR_MAX; k++) begin
      if (push_i && WL_W'(k) < push_len_i)
        mem_q[wptr_q + PTR_W'(k)] <= push_data_i[8*k +: 8];
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 0; k < RD_MAX; k++) begin
      lane_q[k] <= (pop && RL_W'(k) < rd_len_i) ? mem_q[rptr_q + PTR_W'(k)] : 8'h00;
    end
  end

  for (genvar k = 0; k < RD_MAX; k++) begin : g_lane
    assign rd_data_o[8*k +: 8] = lane_q[k];
  end

  assign count_o   = cnt_q;
  assign rd_ok_o   = (res_q == RD_PASS);
  assign rd_fail_o = (res_q == RD_MISS);

endmodule

// File: rtl/dma_read_fifo.sv
module dma_read_fifo #(
  parameter int ADDR_W     = 16,
  parameter int FIFO_BYTES = 16,
  parameter int MAX_REQ    = 4,
  parameter int MAX_PEND   = 4,
  parameter int RD_MAX     = 4,
  localparam int LEN_W     = $clog2(MAX_REQ + 1),
  localparam int TAG_W     = dmaf_pkg::bits_for(MAX_PEND),
  localparam int RL_W      = $clog2(RD_MAX + 1)
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 start_i,
  input  logic [ADDR_W-1:0]    start_addr_i,
  input  logic [ADDR_W-1:0]    start_len_i,
  input  logic                 stop_i,
  input  logic                 flush_i,
  output logic                 req_valid_o,
  input  logic                 req_ready_i,
  output logic [ADDR_W-1:0]    req_addr_o,
  output logic [LEN_W-1:0]     req_len_o,
  output logic [TAG_W-1:0]     req_tag_o,
  input  logic                 rsp_valid_i,
  input  logic [TAG_W-1:0]     rsp_tag_i,
  input  logic [8*MAX_REQ-1:0] rsp_data_i,
  input  logic                 rd_req_i,
  input  logic [RL_W-1:0]      rd_len_i,
  output logic                 rd_ok_o,
  output logic                 rd_fail_o,
  output logic [8*RD_MAX-1:0]  rd_data_o,
  output logic                 eob_o,
  output logic                 active_o,
  output logic                 eob_evt_o,
  output logic                 idle_evt_o,
  output logic                 start_err_o
);

  localparam int CNT_W  = $clog2(FIFO_BYTES + 1);
  localparam int PCNT_W = $clog2(MAX_PEND + 1);

  logic [LEN_W-1:0]     cand_len;
  logic                 fire;
  logic                 slot_free;
  logic [PCNT_W-1:0]    pend_cnt;
  logic                 retire;
  logic                 retire_keep;
  logic [LEN_W-1:0]     retire_len;
  logic [8*MAX_REQ-1:0] retire_data;
  logic                 push;
  logic [CNT_W-1:0]     fifo_cnt;
  logic [CNT_W-1:0]     reserved_q;
  logic [CNT_W:0]       room;
  logic                 was_active_q;

  dmaf_issuer #(.ADDR_W(ADDR_W), .MAX_REQ(MAX_REQ), .LEN_W(LEN_W)) u_issue (
    .clk         (clk),
    .rst         (rst),
    .start_i     (start_i),
    .start_addr_i(start_addr_i),
    .start_len_i (start_len_i),
    .stop_i      (stop_i),
    .fire_i      (fire),
    .cand_addr_o (req_addr_o),
    .cand_len_o  (cand_len),
    .eob_o       (eob_o),
    .eob_evt_o   (eob_evt_o),
    .start_err_o (start_err_o)
  );

  dmaf_slots #(.MAX_PEND(MAX_PEND), .MAX_REQ(MAX_REQ), .LEN_W(LEN_W),
               .TAG_W(TAG_W), .PCNT_W(PCNT_W)) u_slots (
    .clk          (clk),
    .rst          (rst),
    .alloc_i      (fire),
    .alloc_len_i  (cand_len),
    .kill_i       (stop_i),
    .rsp_valid_i  (rsp_valid_i),
    .rsp_tag_i    (rsp_tag_i),
    .rsp_data_i   (rsp_data_i),
    .alloc_tag_o  (req_tag_o),
    .slot_free_o  (slot_free),
    .pend_cnt_o   (pend_cnt),
    .retire_o     (retire),
    .retire_keep_o(retire_keep),
    .retire_len_o (retire_len),
    .retire_data_o(retire_data)
  );

  assign push = retire && retire_keep;

  dmaf_bytefifo #(.DEPTH(FIFO_BYTES), .WR_MAX(MAX_REQ), .RD_MAX(RD_MAX),
                  .CNT_W(CNT_W), .WL_W(LEN_W), .RL_W(RL_W)) u_fifo (
    .clk        (clk),
    .rst        (rst),
    .push_i     (push),
    .push_len_i (retire_len),
    .push_data_i(retire_data),
    .flush_i    (flush_i),
    .rd_req_i   (rd_req_i),
    .rd_len_i   (rd_len_i),
    .count_o    (fifo_cnt),
    .rd_ok_o    (rd_ok_o),
    .rd_fail_o  (rd_fail_o),
    .rd_data_o  (rd_data_o)
  );

  // Bytes not yet stored nor booked by an outstanding request.
  assign room = (CNT_W+1)'(FIFO_BYTES) - {1'b0, fifo_cnt} - {1'b0, reserved_q};

  assign req_valid_o = !eob_o && slot_free && (room >= (CNT_W+1)'(cand_len));
  assign req_len_o   = cand_len;
  assign fire        = req_valid_o && req_ready_i;

  always_ff @(posedge clk) begin
    if (rst) begin
      reserved_q <= '0;
    end else if (stop_i) begin
      reserved_q <= '0;
    end else begin
      reserved_q <= reserved_q + (fire ? CNT_W'(cand_len) : '0)
                               - (push ? CNT_W'(retire_len) : '0);
    end
  end

  assign active_o = !(eob_o && pend_cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) was_active_q <= 1'b0;
    else     was_active_q <= active_o;
  end

  assign idle_evt_o = was_active_q && !active_o;

endmodule

// File: rtl/dmaf_checker.sv
module dmaf_checker #(
  parameter int FIFO_BYTES = 16,
  parameter int MAX_REQ    = 4,
  parameter int MAX_PEND   = 4,
  parameter int CNT_W      = 5,
  parameter int LEN_W      = 3
) (
  input logic             clk,
  input logic             rst,
  input logic             req_valid_o,
  input logic             req_ready_i,
  input logic [LEN_W-1:0] req_len_o,
  input logic             rsp_valid_i,
  input logic             rd_ok_o,
  input logic             rd_fail_o,
  input logic             eob_o,
  input logic             active_o,
  input logic             eob_evt_o,
  input logic             idle_evt_o,
  input logic [CNT_W-1:0] fifo_cnt,
  input logic [CNT_W-1:0] reserved_q
);

  logic [15:0] outstanding_q;

  always_ff @(posedge clk) begin
    if (rst) outstanding_q <= '0;
    else outstanding_q <= outstanding_q + 16'(req_valid_o && req_ready_i) - 16'(rsp_valid_i);
  end

  a_r1_req_len: assert property (@(posedge clk) disable iff (rst)
    req_valid_o |-> (req_len_o != '0 && int'(req_len_o) <= MAX_REQ));

  a_r2_pend_limit: assert property (@(posedge clk) disable iff (rst)
    int'(outstanding_q) <= MAX_PEND);

  a_r3_no_overflow: assert property (@(posedge clk) disable iff (rst)
    int'(fifo_cnt) + int'(reserved_q) <= FIFO_BYTES);

  a_r5_one_result: assert property (@(posedge clk) disable iff (rst)
    !(rd_ok_o && rd_fail_o));

  a_r6_quiet_at_end: assert property (@(posedge clk) disable iff (rst)
    eob_o |-> !req_valid_o);

  a_r9_evt_at_end: assert property (@(posedge clk) disable iff (rst)
    eob_evt_o |-> eob_o);

  a_r10_idle_inactive: assert property (@(posedge clk) disable iff (rst)
    idle_evt_o |-> !active_o);

endmodule

bind dma_read_fifo dmaf_checker #(
  .FIFO_BYTES(FIFO_BYTES), .MAX_REQ(MAX_REQ), .MAX_PEND(MAX_PEND),
  .CNT_W(CNT_W), .LEN_W(LEN_W)
) u_dmaf_checker (
  .clk        (clk),
  .rst        (rst),
  .req_valid_o(req_valid_o),
  .req_ready_i(req_ready_i),
  .req_len_o  (req_len_o),
  .rsp_valid_i(rsp_valid_i),
  .rd_ok_o    (rd_ok_o),
  .rd_fail_o  (rd_fail_o),
  .eob_o      (eob_o),
  .active_o   (active_o),
  .eob_evt_o  (eob_evt_o),
  .idle_evt_o (idle_evt_o),
  .fifo_cnt   (fifo_cnt),
  .reserved_q (reserved_q)
);

// File: tb/dma_read_fifo_bench.sv
`timescale 1ns/1ps
module dma_read_fifo_bench;
  localparam int AW    = 16;
  localparam int FB    = 16;
  localparam int MR    = 4;
  localparam int MP    = 4;
  localparam int RM    = 4;
  localparam int LEN_W = $clog2(MR + 1);
  localparam int TAG_W = (MP <= 1) ? 1 : $clog2(MP);
  localparam int RL_W  = $clog2(RM + 1);

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_i = 0, stop_i = 0, flush_i = 0;
  logic [AW-1:0] start_addr_i = '0, start_len_i = '0;
  logic req_valid_o, req_ready_i = 1'b1;
  logic [AW-1:0] req_addr_o;
  logic [LEN_W-1:0] req_len_o;
  logic [TAG_W-1:0] req_tag_o;
  logic rsp_valid_i = 0;
  logic [TAG_W-1:0] rsp_tag_i = '0;
  logic [8*MR-1:0] rsp_data_i = '0;
  logic rd_req_i = 0;
  logic [RL_W-1:0] rd_len_i = '0;
  logic rd_ok_o, rd_fail_o;
  logic [8*RM-1:0] rd_data_o;
  logic eob_o, active_o, eob_evt_o, idle_evt_o, start_err_o;

  always #4 clk = ~clk;

  dma_read_fifo #(.ADDR_W(AW), .FIFO_BYTES(FB), .MAX_REQ(MR), .MAX_PEND(MP), .RD_MAX(RM))
  u_dma_read_fifo (
    .clk(clk), .rst(rst), .start_i(start_i), .start_addr_i(start_addr_i),
    .start_len_i(start_len_i), .stop_i(stop_i), .flush_i(flush_i),
    .req_valid_o(req_valid_o), .req_ready_i(req_ready_i), .req_addr_o(req_addr_o),
    .req_len_o(req_len_o), .req_tag_o(req_tag_o), .rsp_valid_i(rsp_valid_i),
    .rsp_tag_i(rsp_tag_i), .rsp_data_i(rsp_data_i), .rd_req_i(rd_req_i),
    .rd_len_i(rd_len_i), .rd_ok_o(rd_ok_o), .rd_fail_o(rd_fail_o),
    .rd_data_o(rd_data_o), .eob_o(eob_o), .active_o(active_o),
    .eob_evt_o(eob_evt_o), .idle_evt_o(idle_evt_o), .start_err_o(start_err_o)
  );

  int vectors = 0;
  int fails   = 0;
  bit done    = 0;
  int mode    = 0;            // 0 hold, 1 oldest first, 2 newest first
  int eob_cnt = 0, idle_cnt = 0, issued = 0;
  logic [AW-1:0] exp_next = '0, exp_end = '0;
  logic [AW-1:0] oq_addr[$];
  int            oq_len[$];
  logic [TAG_W-1:0] oq_tag[$];

  function automatic logic [7:0] mem_byte(logic [AW-1:0] a);
    return (a[7:0] * 8'd3) ^ a[15:8] ^ 8'h5C;
  endfunction

  task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic cyc();
    logic evt_due = 1'b0;
    logic stop_now = stop_i;
    if (req_valid_o && req_ready_i) begin
      int left = int'(AW'(exp_end - exp_next));
      int want = (left < MR) ? left : MR;
      chk("R1 addr", 64'(req_addr_o), 64'(exp_next));
      chk("R1 len", 64'(req_len_o), 64'(want));
      oq_addr.push_back(req_addr_o);
      oq_len.push_back(int'(req_len_o));
      oq_tag.push_back(req_tag_o);
      issued += int'(req_len_o);
      if (want == left) evt_due = 1'b1;
      exp_next = exp_next + AW'(req_len_o);
    end
    @(posedge clk); #1;
    if (evt_due && !stop_now || eob_evt_o)
      chk("R9 eob pulse", 64'(eob_evt_o), 64'(evt_due && !stop_now));
    if (eob_evt_o) eob_cnt++;
    if (idle_evt_o) idle_cnt++;
    start_i = 0; stop_i = 0; flush_i = 0; rd_req_i = 0; rsp_valid_i = 0;
    if (oq_tag.size() > MP) chk("R2 outstanding", 64'(oq_tag.size()), 64'(MP));
    if (mode != 0 && oq_tag.size() > 0) begin
      int i = (mode == 1) ? 0 : oq_tag.size() - 1;
      rsp_valid_i = 1;
      rsp_tag_i   = oq_tag[i];
      rsp_data_i  = '0;
      for (int k = 0; k < MR; k++)
        if (k < oq_len[i]) rsp_data_i[8*k +: 8] = mem_byte(oq_addr[i] + AW'(k));
      oq_addr.delete(i); oq_len.delete(i); oq_tag.delete(i);
    end
  endtask

  task automatic wait_n(int n);
    for (int i = 0; i < n; i++) cyc();
  endtask

  task automatic do_start(logic [AW-1:0] a, logic [AW-1:0] l, bit ok);
    start_i = 1; start_addr_i = a; start_len_i = l;
    cyc();
    chk("R7 start_err", 64'(start_err_o), 64'(!ok));
    if (ok) begin exp_next = a; exp_end = a + l; end
  endtask

  task automatic do_read(string req, int n, bit ok, logic [AW-1:0] base, bit fl);
    logic [8*RM-1:0] ev = '0;
    rd_req_i = 1; rd_len_i = RL_W'(n); flush_i = fl;
    cyc();
    chk(req, 64'(rd_ok_o), 64'(ok));
    chk(req, 64'(rd_fail_o), 64'(!ok));
    if (ok) begin
      for (int k = 0; k < RM; k++) if (k < n) ev[8*k +: 8] = mem_byte(base + AW'(k));
      chk({req, " data"}, 64'(rd_data_o), 64'(ev));
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++; vectors++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
      $finish;
    end
  end

  initial begin : main
    int id0, ec0;
    repeat (4) @(posedge clk);
    #1 rst = 0;
    // R12 reset state
    chk("R12 eob", 64'(eob_o), 64'd1);
    chk("R12 active", 64'(active_o), 64'd0);
    chk("R12 req_valid", 64'(req_valid_o), 64'd0);
    do_read("R12 empty read", 1, 0, '0, 0);

    // R2/R3: hold responses, then fill without reading
    mode = 0; issued = 0; id0 = idle_cnt;
    do_start(16'h0100, 16'd64, 1);
    wait_n(10);
    chk("R2 slots full", 64'(oq_tag.size()), 64'(MP));
    chk("R2 stalled", 64'(req_valid_o), 64'd0);
    mode = 1;
    wait_n(30);
    chk("R3 booked bytes", 64'(issued), 64'(FB));
    chk("R3 stalled", 64'(req_valid_o), 64'd0);
    chk("R6 active mid block", 64'(active_o), 64'd1);
    for (int j = 0; j < 16; j++) begin
      do_read("R5 R4 stream", 4, 1, 16'h0100 + AW'(4*j), 0);
      wait_n(8);
    end
    chk("R9 one pulse", 64'(eob_cnt), 64'd1);
    chk("R10 idle once", 64'(idle_cnt - id0), 64'd1);
    chk("R6 idle", 64'(active_o), 64'd0);
    chk("R6 eob", 64'(eob_o), 64'd1);

    // R4/R1: odd address, newest-first answers, reads of varying size
    begin
      logic [AW-1:0] ra = 16'h1233;
      int sz = 1, guard = 0;
      mode = 2;
      do_start(16'h1233, 16'd30, 1);
      while (ra != 16'h1251 && guard < 3000) begin
        int left = int'(AW'(16'h1251 - ra));
        int n = (sz < left) ? sz : left;
        logic [8*RM-1:0] ev = '0;
        rd_req_i = 1; rd_len_i = RL_W'(n);
        cyc();
        if (rd_ok_o) begin
          for (int k = 0; k < RM; k++) if (k < n) ev[8*k +: 8] = mem_byte(ra + AW'(k));
          chk("R4 reordered data", 64'(rd_data_o), 64'(ev));
          ra = ra + AW'(n);
        end
        sz = (sz == RM) ? 1 : sz + 1;
        guard++;
      end
      chk("R4 all bytes", 64'(ra), 64'h1251);
    end

    // R5: refusals leave contents intact
    mode = 1;
    do_start(16'h0200, 16'd2, 1);
    wait_n(10);
    do_read("R5 short", 4, 0, '0, 0);
    do_read("R5 zero len", 0, 0, '0, 0);
    do_read("R5 exact", 2, 1, 16'h0200, 0);
    do_read("R5 now empty", 1, 0, '0, 0);

    // R7/R8/R10: refused start, then stop with reads in flight
    mode = 0; wait_n(4);
    do_start(16'h0300, 16'd40, 1);
    wait_n(8);
    do_start(16'h0900, 16'd8, 0);
    chk("R7 ignored", 64'(req_addr_o), 64'(exp_next));
    id0 = idle_cnt; ec0 = eob_cnt;
    stop_i = 1; cyc(); exp_next = exp_end;
    chk("R8 eob after stop", 64'(eob_o), 64'd1);
    chk("R8 no request", 64'(req_valid_o), 64'd0);
    chk("R10 still active", 64'(active_o), 64'd1);
    mode = 1;
    wait_n(20);
    chk("R10 idle after stop", 64'(idle_cnt - id0), 64'd1);
    chk("R8 no eob pulse", 64'(eob_cnt - ec0), 64'd0);
    do_read("R8 discarded", 1, 0, '0, 0);
    do_start(16'h0700, 16'd0, 0);
    chk("R7 zero len eob", 64'(eob_o), 64'd1);

    // R7/R10: chain a block in the end-of-block pulse cycle
    mode = 0; id0 = idle_cnt;
    do_start(16'h0400, 16'd8, 1);
    for (int g = 0; g < 50 && !eob_evt_o; g++) cyc();
    chk("R9 pulse seen", 64'(eob_evt_o), 64'd1);
    do_start(16'h0500, 16'd4, 1);
    for (int g = 0; g < 20 && oq_tag.size() < 3; g++) cyc();
    chk("R10 no gap", 64'(idle_cnt - id0), 64'd0);
    mode = 2;
    wait_n(20);
    chk("R10 single idle", 64'(idle_cnt - id0), 64'd1);
    do_read("R7 first block", 4, 1, 16'h0400, 0);
    do_read("R7 first block", 4, 1, 16'h0404, 0);
    do_read("R7 chained block", 4, 1, 16'h0500, 0);

    // R11 flush
    mode = 1;
    do_start(16'h0600, 16'd8, 1);
    wait_n(12);
    do_read("R11 read during flush", 4, 0, '0, 1);
    do_read("R11 emptied", 1, 0, '0, 0);

    done = 1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule